// File: doc/BRIEF.md
# Offline PWM Controller Protection and Mode Supervisor

This block is the supervisory state machine of a fixed-frequency offline PWM controller. It takes synchronous comparator flags and decides, clock by clock, whether the gate driver may switch. It sequences a start ramp, normal regulation, burst skipping at very light load, and two kinds of shutdown. The first is a permanent latch. The second is a timed pause followed by a restart. It holds all of the protection timing in prescaled counters: the overload timer, the pause timer, the line drop-out filter, and the two persistence filters on the external latch pin.

The soft-start ramp is a step index that the analog setpoint path turns into a current limit. The feedback loop overrides that ramp outside this block whenever it asks for less current. The state is exported as a 3-bit code. A single parameter chooses whether an overload fault ends in the latch or in the timed pause. All durations are given in clock cycles, so a short-timer variant or a fast test bench only needs different parameter values.

Top module: `pwmSupervisor`

## Requirements
- R1: During and right after reset, `status` is 0 (Stopped), and `drvEnable`, `ssActive` and `ssStep` are all 0. The status codes are 0 Stopped, 1 Soft-start, 2 Running, 3 Skip, 4 Latched and 5 Recovery-wait.
- R2: A start request in Stopped moves to Soft-start at the next edge with `ssStep` = 1. `ssStep` rises by one every STEP_CYC cycles up to RAMP_STEPS. The state becomes Running after RAMP_STEPS*STEP_CYC cycles, with `ssStep` left at RAMP_STEPS. `drvEnable` is 1 exactly in Soft-start and Running. `ssActive`, which also doubles the latch-pin bias current, is 1 only in Soft-start.
- R3: In Running, `skipIn` enters Skip at the next edge. In Skip the driver is off and the step stays at RAMP_STEPS, and `skipOut` returns the state to Running.
- R4: The setpoint-at-clamp or max-duty flag, held for FAULT_CYC consecutive cycles in Soft-start or Running, raises an overload fault. A shorter run has no effect, and the count restarts from zero.
- R5: `csStop` in Soft-start, Running or Skip raises a fault at the next edge.
- R6: With AUTO_RECOVER = 0 a fault leads to Latched (4). With AUTO_RECOVER = 1 it leads to Recovery-wait (5) for RECOV_CYC cycles, then to Stopped, where the block waits for a new start request.
- R7: `latchHigh` held for HI_CYC consecutive cycles in Soft-start, Running, Skip or Recovery-wait leads to Latched in both policies. A shorter pulse is ignored.
- R8: `latchLow` held for LO_CYC consecutive cycles in Running, Skip or Recovery-wait leads to Latched. During Soft-start it is ignored.
- R9: `vccOvp` in Soft-start, Running, Skip or Recovery-wait leads to Latched at the next edge in both policies.
- R10: Latched is not left on a start request, `vccOff` or `thermalShut`. Only `vccReset` or a declared brown-out releases it, to Stopped.
- R11: `lineLow` held for LINE_CYC consecutive cycles declares a brown-out and forces Stopped from any state. A shorter drop-out is ignored.
- R12: `thermalShut` forces Stopped from any state except Latched. `vccOff` forces Stopped from Soft-start, Running or Skip. Each takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Supply reached its turn-on level |
| lineLow | input | 1 | Line voltage below the stop level |
| thermalShut | input | 1 | Die over-temperature |
| vccOff | input | 1 | Supply below its turn-off level |
| vccOvp | input | 1 | Supply over-voltage |
| vccReset | input | 1 | Supply below the logic reset level |
| setpointAtClamp | input | 1 | Current setpoint sits at its maximum |
| dutyLimitHit | input | 1 | Last cycle was ended by the duty limit |
| csStop | input | 1 | Sensed current above 1.5 times the clamp |
| skipIn | input | 1 | Feedback below the skip-entry level |
| skipOut | input | 1 | Feedback above the skip-exit level |
| latchHigh | input | 1 | Latch pin above its upper threshold |
| latchLow | input | 1 | Latch pin below its lower threshold |
| drvEnable | output | 1 | Gate driver may switch |
| ssActive | output | 1 | Soft-start in progress, latch bias doubled |
| ssStep | output | 4 | Soft-start setpoint step |
| status | output | 3 | Current state code |

## Verification
Every internal state appears directly on `status` one edge after it is entered, so a wrong transition shows up at the very next sample. A persistence counter that is off by one moves the entry into Latched, Stopped or Recovery-wait by exactly one cycle. The bench catches this by sampling the cycle just before and just after each expected expiry. A ramp counter error changes `ssStep` within one step period, and a misrouted fault policy makes the two instances built with opposite policies diverge in a way the bench does not expect.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_SKIP  = 3'd3,
    ST_LATCH = 3'd4,
    ST_WAIT  = 3'd5
  } supvState_t;

  // strobes from the control FSM to the timer datapath
  typedef struct packed {
    logic hiEn;
    logic loEn;
    logic faultEn;
    logic recovEn;
    logic rampLoad;
    logic rampRun;
    logic rampClear;
  } supvCtrl_t;

  // events from the timer datapath back to the control FSM
  typedef struct packed {
    logic hiTrip;
    logic loTrip;
    logic faultDone;
    logic brownOut;
    logic recovDone;
    logic rampDone;
  } supvEvt_t;

endpackage

// File: rtl/supvPersist.sv
// Persistence filter: trip asserts once sig has been high, with en, for N
// consecutive sampled cycles, and stays high while both remain high.
module supvPersist #(
  parameter int unsigned N = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic sig,
  output logic trip
);
  localparam int unsigned W = (N < 2) ? 1 : $clog2(N);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (!(en && sig)) cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign trip = en && sig && (cnt == LAST);
endmodule

// File: rtl/supvDatapath.sv
module supvDatapath
  import supv_pkg::*;
#(
  parameter int unsigned FAULT_CYC  = 20,
  parameter int unsigned RECOV_CYC  = 30,
  parameter int unsigned LINE_CYC   = 12,
  parameter int unsigned HI_CYC     = 5,
  parameter int unsigned LO_CYC     = 9,
  parameter int unsigned STEP_CYC   = 4,
  parameter int unsigned RAMP_STEPS = 15,
  parameter int unsigned STEP_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  supvCtrl_t         ctrl,
  input  logic              lineLow,
  input  logic              latchHigh,
  input  logic              latchLow,
  input  logic              overload,
  output supvEvt_t          evt,
  output logic [STEP_W-1:0] rampStep
);
  localparam int unsigned NFILT  = 5;
  localparam int unsigned TICK_W = (STEP_CYC < 2) ? 1 : $clog2(STEP_CYC);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(STEP_CYC - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(RAMP_STEPS);

  function automatic int unsigned filtLimit(input int idx);
    case (idx)
      0:       return HI_CYC;
      1:       return LO_CYC;
      2:       return FAULT_CYC;
      3:       return LINE_CYC;
      default: return RECOV_CYC;
    endcase
  endfunction

  logic [NFILT-1:0] fEn, fSig, fTrip;

  // index: 0 latch-high, 1 latch-low, 2 overload, 3 line, 4 recovery pause
  assign fEn  = {ctrl.recovEn, 1'b1,    ctrl.faultEn, ctrl.loEn, ctrl.hiEn};
  assign fSig = {1'b1,         lineLow, overload,     latchLow,  latchHigh};

  for (genvar g = 0; g < NFILT; g++) begin : gFilt
    supvPersist #(.N(filtLimit(g))) uFilt (
      .clk  (clk),
      .rstN (rstN),
      .en   (fEn[g]),
      .sig  (fSig[g]),
      .trip (fTrip[g])
    );
  end

  // soft-start ramp: step index held for STEP_CYC cycles each
  logic [TICK_W-1:0] tick;
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tick <= '0;
      step <= '0;
    end else if (ctrl.rampClear) begin
      tick <= '0;
      step <= '0;
    end else if (ctrl.rampLoad) begin
      tick <= '0;
      step <= STEP_W'(1);
    end else if (ctrl.rampRun) begin
      if (tick == TICK_LAST) begin
        tick <= '0;
        if (step != STEP_LAST) step <= step + 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  assign rampStep = step;

  always_comb begin
    evt.hiTrip    = fTrip[0];
    evt.loTrip    = fTrip[1];
    evt.faultDone = fTrip[2];
    evt.brownOut  = fTrip[3];
    evt.recovDone = fTrip[4];
    evt.rampDone  = ctrl.rampRun && (step == STEP_LAST) && (tick == TICK_LAST);
  end
endmodule

// File: rtl/supvControl.sv
module supvControl
  import supv_pkg::*;
#(
  parameter bit AUTO_RECOVER = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       thermalShut,
  input  logic       vccOff,
  input  logic       vccOvp,
  input  logic       vccReset,
  input  logic       csStop,
  input  logic       skipIn,
  input  logic       skipOut,
  input  supvEvt_t   evt,
  output supvCtrl_t  ctrl,
  output supvState_t state,
  output logic       drvEnable,
  output logic       ssActive
);
  localparam supvState_t TRIP_STATE = AUTO_RECOVER ? ST_WAIT : ST_LATCH;

  supvState_t nextState;
  logic isActive, nextActive, latchEvt, faultEvt;

  assign isActive = (state == ST_SOFT) || (state == ST_RUN) || (state == ST_SKIP);
  assign latchEvt = vccOvp || evt.hiTrip || evt.loTrip;
  assign faultEvt = csStop || evt.faultDone;

  always_comb begin
    nextState = state;
    if (evt.brownOut || vccReset) begin
      nextState = ST_STOP;
    end else if (state == ST_LATCH) begin
      nextState = ST_LATCH;
    end else if (thermalShut) begin
      nextState = ST_STOP;
    end else begin
      case (state)
        ST_STOP: if (startReq) nextState = ST_SOFT;
        ST_WAIT: begin
          if (latchEvt)           nextState = ST_LATCH;
          else if (evt.recovDone) nextState = ST_STOP;
        end
        ST_SOFT, ST_RUN, ST_SKIP: begin
          if (latchEvt)      nextState = ST_LATCH;
          else if (faultEvt) nextState = TRIP_STATE;
          else if (vccOff)   nextState = ST_STOP;
          else if (state == ST_SOFT && evt.rampDone) nextState = ST_RUN;
          else if (state == ST_RUN  && skipIn)       nextState = ST_SKIP;
          else if (state == ST_SKIP && skipOut)      nextState = ST_RUN;
        end
        default: nextState = ST_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_STOP;
    else       state <= nextState;
  end

  assign nextActive = (nextState == ST_SOFT) || (nextState == ST_RUN) || (nextState == ST_SKIP);

  always_comb begin
    ctrl.hiEn      = isActive || (state == ST_WAIT);
    ctrl.loEn      = (state == ST_RUN) || (state == ST_SKIP) || (state == ST_WAIT);
    ctrl.faultEn   = (state == ST_SOFT) || (state == ST_RUN);
    ctrl.recovEn   = (state == ST_WAIT);
    ctrl.rampRun   = (state == ST_SOFT);
    ctrl.rampLoad  = (nextState == ST_SOFT) && (state != ST_SOFT);
    ctrl.rampClear = !nextActive;
  end

  assign drvEnable = (state == ST_SOFT) || (state == ST_RUN);
  assign ssActive  = (state == ST_SOFT);
endmodule

// File: rtl/pwmSupervisor.sv
module pwmSupervisor
  import supv_pkg::*;
#(
  parameter int unsigned FAULT_CYC    = 6_400_000,
  parameter int unsigned RECOV_CYC    = 50_000_000,
  parameter int unsigned LINE_CYC     = 3_400_000,
  parameter int unsigned HI_CYC       = 2_500,
  parameter int unsigned LO_CYC       = 17_500,
  parameter int unsigned STEP_CYC     = 13_333,
  parameter int unsigned RAMP_STEPS   = 15,
  parameter bit          AUTO_RECOVER = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic lineLow,
  input  logic thermalShut,
  input  logic vccOff,
  input  logic vccOvp,
  input  logic vccReset,
  input  logic setpointAtClamp,
  input  logic dutyLimitHit,
  input  logic csStop,
  input  logic skipIn,
  input  logic skipOut,
  input  logic latchHigh,
  input  logic latchLow,
  output logic drvEnable,
  output logic ssActive,
  output logic [$clog2(RAMP_STEPS+1)-1:0] ssStep,
  output logic [2:0] status
);
  localparam int unsigned STEP_W = $clog2(RAMP_STEPS + 1);

  supvCtrl_t  ctrl;
  supvEvt_t   evt;
  supvState_t state;

  supvControl #(.AUTO_RECOVER(AUTO_RECOVER)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .thermalShut (thermalShut),
    .vccOff      (vccOff),
    .vccOvp      (vccOvp),
    .vccReset    (vccReset),
    .csStop      (csStop),
    .skipIn      (skipIn),
    .skipOut     (skipOut),
    .evt         (evt),
    .ctrl        (ctrl),
    .state       (state),
    .drvEnable   (drvEnable),
    .ssActive    (ssActive)
  );

  supvDatapath #(
    .FAULT_CYC  (FAULT_CYC),
    .RECOV_CYC  (RECOV_CYC),
    .LINE_CYC   (LINE_CYC),
    .HI_CYC     (HI_CYC),
    .LO_CYC     (LO_CYC),
    .STEP_CYC   (STEP_CYC),
    .RAMP_STEPS (RAMP_STEPS),
    .STEP_W     (STEP_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .lineLow   (lineLow),
    .latchHigh (latchHigh),
    .latchLow  (latchLow),
    .overload  (setpointAtClamp | dutyLimitHit),
    .evt       (evt),
    .rampStep  (ssStep)
  );

  assign status = state;
endmodule

// File: rtl/pwmSupervisorChk.sv
module pwmSupervisorChk
  import supv_pkg::*;
#(
  parameter int unsigned STEP_W     = 4,
  parameter int unsigned RAMP_STEPS = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              lineLow,
  input logic              thermalShut,
  input logic              vccReset,
  input logic              vccOvp,
  input logic              csStop,
  input logic              drvEnable,
  input logic [STEP_W-1:0] ssStep,
  input logic [2:0]        status
);
  localparam logic [STEP_W-1:0] FULL = STEP_W'(RAMP_STEPS);

  logic quiet;
  assign quiet = !thermalShut && !vccReset && !lineLow;

  assert_start_ramp_R2: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_STOP && startReq && quiet) |=> (status == ST_SOFT && ssStep == STEP_W'(1)));

  assert_step_monotonic_R2: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_SOFT && $past(status) == ST_SOFT) |->
      (ssStep == $past(ssStep) || ssStep == $past(ssStep) + 1'b1));

  assert_ramp_full_on_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(status) == ST_SOFT && status == ST_RUN) |-> (ssStep == FULL));

  assert_skip_driver_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_SKIP) |-> !drvEnable);

  assert_cs_stop_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((status == ST_SOFT || status == ST_RUN || status == ST_SKIP) && csStop && quiet) |=>
      (status == ST_LATCH || status == ST_WAIT));

  assert_wait_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(status) == ST_WAIT && status != ST_WAIT) |-> (status == ST_STOP || status == ST_LATCH));

  assert_ovp_latch_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((status == ST_SOFT || status == ST_RUN || status == ST_SKIP || status == ST_WAIT)
      && vccOvp && quiet) |=> (status == ST_LATCH));

  assert_latched_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_LATCH) |=> (status == ST_LATCH || status == ST_STOP));

  assert_latched_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(status) == ST_LATCH && status == ST_STOP) |-> ($past(vccReset) || $past(lineLow)));
endmodule

bind pwmSupervisor pwmSupervisorChk #(.STEP_W(STEP_W), .RAMP_STEPS(RAMP_STEPS)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startReq    (startReq),
  .lineLow     (lineLow),
  .thermalShut (thermalShut),
  .vccReset    (vccReset),
  .vccOvp      (vccOvp),
  .csStop      (csStop),
  .drvEnable   (drvEnable),
  .ssStep      (ssStep),
  .status      (status)
);

// File: tb/test_pwmSupervisor.sv
module test_pwmSupervisor;
  localparam int F  = 20;
  localparam int RC = 30;
  localparam int L  = 12;
  localparam int HI = 5;
  localparam int LO = 9;
  localparam int SS = 4;
  localparam int NSTEP = 15;
  localparam int SS_LEN = NSTEP * SS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 0, lineLow = 0, thermalShut = 0, vccOff = 0, vccOvp = 0, vccReset = 0;
  logic setpointAtClamp = 0, dutyLimitHit = 0, csStop = 0, skipIn = 0, skipOut = 0;
  logic latchHigh = 0, latchLow = 0;

  logic drvA, ssA, drvB, ssB;
  logic [3:0] stepA, stepB;
  logic [2:0] statA, statB;

  always #10 clk = ~clk;

  // unit A: latching policy
  pwmSupervisor #(.FAULT_CYC(F), .RECOV_CYC(RC), .LINE_CYC(L), .HI_CYC(HI), .LO_CYC(LO),
                  .STEP_CYC(SS), .RAMP_STEPS(NSTEP), .AUTO_RECOVER(1'b0)) i_pwmSupervisor (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lineLow(lineLow), .thermalShut(thermalShut),
    .vccOff(vccOff), .vccOvp(vccOvp), .vccReset(vccReset), .setpointAtClamp(setpointAtClamp),
    .dutyLimitHit(dutyLimitHit), .csStop(csStop), .skipIn(skipIn), .skipOut(skipOut),
    .latchHigh(latchHigh), .latchLow(latchLow),
    .drvEnable(drvA), .ssActive(ssA), .ssStep(stepA), .status(statA));

  // unit B: auto-recovery policy
  pwmSupervisor #(.FAULT_CYC(F), .RECOV_CYC(RC), .LINE_CYC(L), .HI_CYC(HI), .LO_CYC(LO),
                  .STEP_CYC(SS), .RAMP_STEPS(NSTEP), .AUTO_RECOVER(1'b1)) i_pwmSupervisor_rec (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lineLow(lineLow), .thermalShut(thermalShut),
    .vccOff(vccOff), .vccOvp(vccOvp), .vccReset(vccReset), .setpointAtClamp(setpointAtClamp),
    .dutyLimitHit(dutyLimitHit), .csStop(csStop), .skipIn(skipIn), .skipOut(skipOut),
    .latchHigh(latchHigh), .latchLow(latchLow),
    .drvEnable(drvB), .ssActive(ssB), .ssStep(stepB), .status(statB));

  typedef struct {
    int    due;
    int    sa;
    int    sb;
    int    pa;
    int    pb;
    string tag;
  } expItem_t;

  expItem_t q[$];
  int edgeCnt = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  // scoreboard driver side
  task automatic expectAt(input int d, input int sa, input int sb, input int pa, input int pb,
                          input string tag);
    expItem_t it;
    it.due = edgeCnt + d;
    it.sa = sa; it.sb = sb; it.pa = pa; it.pb = pb; it.tag = tag;
    q.push_back(it);
  endtask

  function automatic bit unitOk(input int s, input int p, input logic [2:0] st,
                                input logic drv, input logic ssa, input logic [3:0] stp);
    bit expDrv = (s == 1) || (s == 2);
    bit expSs  = (s == 1);
    return (int'(st) == s) && (drv == expDrv) && (ssa == expSs) && (p < 0 || int'(stp) == p);
  endfunction

  // scoreboard monitor side
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == edgeCnt) begin
        checks++;
        if (!unitOk(q[i].sa, q[i].pa, statA, drvA, ssA, stepA) ||
            !unitOk(q[i].sb, q[i].pb, statB, drvB, ssB, stepB)) begin
          fails++;
          $display("FAIL %s: actual A st=%0d drv=%0d ss=%0d step=%0d B st=%0d drv=%0d ss=%0d step=%0d; expected A st=%0d step=%0d B st=%0d step=%0d",
                   q[i].tag, statA, drvA, ssA, stepA, statB, drvB, ssB, stepB,
                   q[i].sa, q[i].pa, q[i].sb, q[i].pb);
        end
        q.delete(i);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resetBoth(input string tag);
    vccReset = 1'b1;
    expectAt(1, 0, 0, 0, 0, tag);
    cyc(1);
    vccReset = 1'b0;
    cyc(2);
  endtask

  task automatic startBoth();
    startReq = 1'b1;
    cyc(1);
    startReq = 1'b0;
  endtask

  initial begin
    cyc(3);
    expectAt(1, 0, 0, 0, 0, "R1 in reset");
    expectAt(2, 0, 0, 0, 0, "R1 after reset");
    cyc(1);
    rstN = 1'b1;
    cyc(3);

    // R2: start and ramp
    startReq = 1'b1;
    expectAt(1, 1, 1, 1, 1, "R2 start");
    expectAt(SS, 1, 1, 1, 1, "R2 step hold");
    expectAt(SS + 1, 1, 1, 2, 2, "R2 step advance");
    expectAt(SS_LEN, 1, 1, 15, 15, "R2 last step");
    expectAt(SS_LEN + 1, 2, 2, 15, 15, "R2 running");
    cyc(1);
    startReq = 1'b0;
    cyc(SS_LEN);

    // R3: skip
    skipIn = 1'b1;
    expectAt(1, 3, 3, 15, 15, "R3 skip entry");
    cyc(1);
    skipIn = 1'b0;
    expectAt(2, 3, 3, 15, 15, "R3 skip held");
    cyc(2);
    skipOut = 1'b1;
    expectAt(1, 2, 2, 15, 15, "R3 skip exit");
    cyc(1);
    skipOut = 1'b0;
    cyc(2);

    // R4: short overload ignored, full one trips; R6 policies
    setpointAtClamp = 1'b1;
    cyc(F - 1);
    setpointAtClamp = 1'b0;
    expectAt(1, 2, 2, 15, 15, "R4 short overload ignored");
    cyc(3);
    dutyLimitHit = 1'b1;
    expectAt(F - 1, 2, 2, 15, 15, "R4 before expiry");
    expectAt(F, 4, 5, 0, 0, "R4 R6 overload expiry");
    cyc(F);
    dutyLimitHit = 1'b0;
    expectAt(RC - 1, 4, 5, 0, 0, "R6 recovery wait");
    expectAt(RC, 4, 0, 0, 0, "R6 recovery done");
    cyc(RC);
    expectAt(3, 4, 0, 0, 0, "R6 awaits start");
    cyc(3);

    // R10: latched holds against thermal, uvlo and start
    thermalShut = 1'b1;
    vccOff = 1'b1;
    expectAt(1, 4, 0, 0, 0, "R10 latched holds thermal/uvlo");
    cyc(1);
    thermalShut = 1'b0;
    vccOff = 1'b0;
    startReq = 1'b1;
    expectAt(1, 4, 1, 0, 1, "R10 R6 start after recovery");
    cyc(1);
    startReq = 1'b0;
    cyc(2);
    resetBoth("R10 vcc reset release");

    // R5: cs stop
    startBoth();
    cyc(3);
    csStop = 1'b1;
    expectAt(1, 4, 5, 0, 0, "R5 cs stop");
    cyc(1);
    csStop = 1'b0;
    resetBoth("R10 reset after cs stop");

    // R7: latch high persistence
    startBoth();
    latchHigh = 1'b1;
    cyc(HI - 1);
    latchHigh = 1'b0;
    expectAt(1, 1, 1, -1, -1, "R7 short high ignored");
    cyc(2);
    latchHigh = 1'b1;
    expectAt(HI - 1, 1, 1, -1, -1, "R7 before blanking");
    expectAt(HI, 4, 4, 0, 0, "R7 high latch both policies");
    cyc(HI);
    latchHigh = 1'b0;
    resetBoth("R10 reset after high latch");

    // R8: latch low masked in soft-start, honoured in running
    startBoth();
    latchLow = 1'b1;
    cyc(2 * LO);
    latchLow = 1'b0;
    expectAt(1, 1, 1, -1, -1, "R8 low ignored in soft-start");
    cyc(SS_LEN - 2 * LO);
    expectAt(1, 2, 2, 15, 15, "R8 running after masked low");
    latchLow = 1'b1;
    expectAt(LO - 1, 2, 2, 15, 15, "R8 before blanking");
    expectAt(LO, 4, 4, 0, 0, "R8 low latch");
    cyc(LO);
    latchLow = 1'b0;
    resetBoth("R10 reset after low latch");

    // R9 then R11 release of latched state by brown-out
    startBoth();
    cyc(2);
    vccOvp = 1'b1;
    expectAt(1, 4, 4, 0, 0, "R9 overvoltage latch");
    cyc(1);
    vccOvp = 1'b0;
    lineLow = 1'b1;
    cyc(L - 1);
    lineLow = 1'b0;
    expectAt(1, 4, 4, 0, 0, "R11 short dropout ignored");
    cyc(2);
    lineLow = 1'b1;
    expectAt(L - 1, 4, 4, 0, 0, "R11 before brown-out");
    expectAt(L, 0, 0, 0, 0, "R10 R11 brown-out release");
    cyc(L);
    lineLow = 1'b0;
    cyc(2);

    // R12: thermal and uvlo
    startBoth();
    cyc(SS_LEN);
    thermalShut = 1'b1;
    expectAt(1, 0, 0, 0, 0, "R12 thermal stop from running");
    cyc(1);
    thermalShut = 1'b0;
    startReq = 1'b1;
    expectAt(1, 1, 1, 1, 1, "R2 restart");
    cyc(1);
    startReq = 1'b0;
    cyc(2);
    vccOff = 1'b1;
    expectAt(1, 0, 0, 0, 0, "R12 uvlo stop");
    cyc(1);
    vccOff = 1'b0;
    cyc(2);

    // R11: brown-out from soft-start
    startBoth();
    cyc(2);
    lineLow = 1'b1;
    expectAt(L - 1, 1, 1, -1, -1, "R11 filter");
    expectAt(L, 0, 0, 0, 0, "R11 brown-out stop");
    cyc(L);
    lineLow = 1'b0;
    cyc(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule